// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches one bank of general-purpose input pins and raises a single interrupt line when any unmasked pin sees its configured trigger. Each pin picks its trigger from three per-pin configuration bits: a kind bit (edge or level), a polarity bit and a both-edges bit. Together they give rising edge, falling edge, either edge, active-high level or active-low level. The pin inputs are assumed to be already synchronised to the block clock.

A detected trigger latches into a per-pin event bit. Software clears an event bit by writing 1 to it. Masking is done through two write-only strobes: one adds pins to the mask and the other removes them. A read-only view shows the current mask. The mask only gates propagation, so detection and latching keep running on masked pins. An event caught while a pin is masked therefore raises the interrupt as soon as that pin is unmasked. Software reaches the registers through a simple single-cycle write strobe with a combinational read.

Top module: `gpio_irq_det`

## Requirements
- R1: While reset is held and right after it, every mask bit reads 1, and the event, kind, polarity and both-edges registers read 0. `irq` is 0.
- R2: With kind=1, polarity=1 and both-edges=0, a 0-to-1 change of a pin sets its event bit on the clock edge where the new value is first sampled. No other change sets the bit.
- R3: With kind=1, polarity=0 and both-edges=0, only a 1-to-0 change of a pin sets its event bit.
- R4: With kind=1 and both-edges=1, any change of a pin sets its event bit, whatever the polarity bit holds. A pin that holds steady in edge mode never produces an event.
- R5: With kind=0, a pin whose level equals its polarity bit sets its event bit on every clock. The both-edges bit has no effect in this mode. A clear therefore only sticks once the level is inactive.
- R6: Writing to offset 0x18 clears each event bit where the write data holds 1. Bits written as 0 keep their value. Reading offset 0x18 returns the event bits.
- R7: If a pin's trigger and a clear of that pin's event bit land on the same clock, the event bit ends up 1.
- R8: Writing offset 0x14 sets the mask bits where the data holds 1. Writing offset 0x10 clears the mask bits where the data holds 1. Zero data bits leave the mask unchanged, and a write of all ones to 0x14 masks every pin in one access. Offset 0x0C reads the mask, and writes to 0x0C are ignored.
- R9: `irq` is 1 exactly when some pin has its event bit 1 and its mask bit 0. Events are still latched on masked pins.
- R10: Offsets 0x1C (kind), 0x20 (polarity) and 0x24 (both-edges) read back what was written. Offsets 0x10, 0x14 and every unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Synchronised pin levels |
| irq | output | 1 | Combined interrupt, high while any unmasked event is pending |

## Verification
The assertions assume that `pin_in` changes only between clock edges, and that reset is held for at least one edge before the first checked cycle. Under that assumption, the value sampled on the previous edge is a trustworthy reference for edge detection. The bench changes pins and bus signals only on falling clock edges, and it holds reset for several cycles. Its main sweep gives each of the 32 pins a different combination of configuration bits and before/after levels, so every trigger setting meets every transition in a single pass. The sweep is then repeated with the assignment rotated across pins.

// File: rtl/gid_pkg.sv
package gid_pkg;

  // Register offsets seen by software
  localparam int unsigned OFS_MASK_VIEW = 32'h0C;
  localparam int unsigned OFS_UNMASK    = 32'h10;
  localparam int unsigned OFS_MASK_SET  = 32'h14;
  localparam int unsigned OFS_EVENT     = 32'h18;
  localparam int unsigned OFS_KIND      = 32'h1C;
  localparam int unsigned OFS_POL       = 32'h20;
  localparam int unsigned OFS_BOTH      = 32'h24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK_VIEW,
    SEL_UNMASK,
    SEL_MASK_SET,
    SEL_EVENT,
    SEL_KIND,
    SEL_POL,
    SEL_BOTH
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input int unsigned ofs);
    case (ofs)
      OFS_MASK_VIEW: return SEL_MASK_VIEW;
      OFS_UNMASK:    return SEL_UNMASK;
      OFS_MASK_SET:  return SEL_MASK_SET;
      OFS_EVENT:     return SEL_EVENT;
      OFS_KIND:      return SEL_KIND;
      OFS_POL:       return SEL_POL;
      OFS_BOTH:      return SEL_BOTH;
      default:       return SEL_NONE;
    endcase
  endfunction

  // Trigger decision for one pin: cur is the level now, prev one cycle ago
  function automatic logic trig_hit(input logic kind, input logic pol,
                                    input logic both, input logic cur,
                                    input logic prev);
    if (!kind)     return cur == pol;
    else if (both) return cur ^ prev;
    else           return (cur == pol) && (prev != pol);
  endfunction

endpackage

// File: rtl/gid_regs.sv
module gid_regs #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic [NPINS-1:0]  status_q,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NPINS-1:0]  kind_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  clr_vec,
  output logic              wr_unmask,
  output logic              wr_maskset
);
  import gid_pkg::*;

  reg_sel_e sel;
  assign sel        = decode_sel(32'(bus_addr));
  assign wr_unmask  = bus_wr && (sel == SEL_UNMASK);
  assign wr_maskset = bus_wr && (sel == SEL_MASK_SET);
  assign clr_vec    = (bus_wr && (sel == SEL_EVENT)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      kind_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else begin
      if (wr_maskset)      mask_q <= mask_q | bus_wdata;
      else if (wr_unmask)  mask_q <= mask_q & ~bus_wdata;
      if (bus_wr && sel == SEL_KIND) kind_q <= bus_wdata;
      if (bus_wr && sel == SEL_POL)  pol_q  <= bus_wdata;
      if (bus_wr && sel == SEL_BOTH) both_q <= bus_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_MASK_VIEW: bus_rdata = mask_q;
      SEL_EVENT:     bus_rdata = status_q;
      SEL_KIND:      bus_rdata = kind_q;
      SEL_POL:       bus_rdata = pol_q;
      SEL_BOTH:      bus_rdata = both_q;
      default:       bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gid_detect.sv
module gid_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] kind_q,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] both_q,
  output logic [NPINS-1:0] evt_vec
);
  import gid_pkg::*;

  // Previous level: follows the input during reset too, so the first
  // cycle after reset sees no change that did not happen.
  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk) pin_q <= pin_in;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign evt_vec[i] = trig_hit(kind_q[i], pol_q[i], both_q[i],
                                 pin_in[i], pin_q[i]);
  end

endmodule

// File: rtl/gid_status.sv
module gid_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_vec,
  input  logic [NPINS-1:0] clr_vec,
  input  logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] status_q,
  output logic             irq
);

  // A new event outranks a clear on the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | evt_vec;
  end

  assign irq = |(status_q & ~mask_q);

endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq
);

  // Named internal events, visible to the bound checker
  logic [NPINS-1:0] kind_q, pol_q, both_q, mask_q;
  logic [NPINS-1:0] status_q, evt_vec, clr_vec;
  logic             wr_unmask, wr_maskset;

  gid_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status_q   (status_q),
    .bus_rdata  (bus_rdata),
    .kind_q     (kind_q),
    .pol_q      (pol_q),
    .both_q     (both_q),
    .mask_q     (mask_q),
    .clr_vec    (clr_vec),
    .wr_unmask  (wr_unmask),
    .wr_maskset (wr_maskset)
  );

  gid_detect #(.NPINS(NPINS)) u_detect (
    .clk     (clk),
    .pin_in  (pin_in),
    .kind_q  (kind_q),
    .pol_q   (pol_q),
    .both_q  (both_q),
    .evt_vec (evt_vec)
  );

  gid_status #(.NPINS(NPINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_vec  (evt_vec),
    .clr_vec  (clr_vec),
    .mask_q   (mask_q),
    .status_q (status_q),
    .irq      (irq)
  );

endmodule

// File: rtl/gid_checker.sv
module gid_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] evt_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] status_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] kind_q,
  input logic             wr_unmask,
  input logic             wr_maskset,
  input logic             irq
);

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_vec)) == $past(evt_vec))); // R7

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_vec & ~evt_vec)) == '0)); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_vec)) == '0)); // R2

  AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_q & ~(pin_in ^ $past(pin_in)) & evt_vec) == '0)); // R4

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_maskset |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R8

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask_q & $past(bus_wdata)) == '0)); // R8

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq); // R9

endmodule

bind gpio_irq_det gid_checker #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_in     (pin_in),
  .bus_wdata  (bus_wdata),
  .evt_vec    (evt_vec),
  .clr_vec    (clr_vec),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .kind_q     (kind_q),
  .wr_unmask  (wr_unmask),
  .wr_maskset (wr_maskset),
  .irq        (irq)
);

// File: tb/gpio_irq_det_test.sv
module gpio_irq_det_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam logic [7:0] A_MASK = 8'h0C, A_UNMASK = 8'h10, A_MSET = 8'h14,
                         A_EVT = 8'h18, A_KIND = 8'h1C, A_POL = 8'h20,
                         A_BOTH = 8'h24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '1;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  gpio_irq_det #(.NPINS(NP), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [NP-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Independent model: level of A that re-sets after the clear, plus
  // the trigger seen when the pin moves from a to b
  function automatic logic model_bit(input logic k, input logic p,
                                     input logic bo, input logic a,
                                     input logic b);
    logic lvl_a, hit_b;
    lvl_a = !k && (a == p);
    if (!k)      hit_b = (b == p);
    else if (bo) hit_b = (a != b);
    else         hit_b = (b == p) && (a != p);
    return lvl_a | hit_b;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before the sequence ended");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] d, kv, pv, bv, av, bb, ex;
    repeat (3) @(negedge clk);

    // R1 reset values, read while reset is held
    rd(A_MASK, d);  chk("R1 mask", d, '1);
    rd(A_EVT, d);   chk("R1 event", d, '0);
    rd(A_KIND, d);  chk("R1 kind", d, '0);
    rd(A_POL, d);   chk("R1 polarity", d, '0);
    rd(A_BOTH, d);  chk("R1 both", d, '0);
    chk("R1 irq", {31'b0, irq}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_EVT, d);   chk("R1 event after release", d, '0);

    // Sweep: pin i takes combination (i + 8*rot) mod 32:
    // bit0 both, bit1 polarity, bit2 kind, bit3 level before, bit4 after
    for (int rot = 0; rot < 4; rot++) begin
      ex = '0;
      for (int i = 0; i < NP; i++) begin
        logic [4:0] c;
        c = 5'((i + 8 * rot) % 32);
        bv[i] = c[0]; pv[i] = c[1]; kv[i] = c[2]; av[i] = c[3]; bb[i] = c[4];
        ex[i] = model_bit(c[2], c[1], c[0], c[3], c[4]);
      end
      wr(A_KIND, kv); wr(A_POL, pv); wr(A_BOTH, bv);
      pin_in = av;
      repeat (2) @(negedge clk);
      wr(A_EVT, '1);
      pin_in = bb;
      @(negedge clk);
      rd(A_EVT, d);
      chk("R2/R3/R4/R5 sweep event bits", d, ex);
      chk("R9 sweep masked irq", {31'b0, irq}, '0);
      wr(A_UNMASK, '1);
      chk("R9 sweep unmasked irq", {31'b0, irq}, {31'b0, |ex});
      wr(A_MSET, '1);
    end

    // R7 trigger and clear on the same cycle: trigger wins
    wr(A_KIND, '1); wr(A_POL, '1); wr(A_BOTH, '0);
    pin_in = '0;
    repeat (2) @(negedge clk);
    wr(A_EVT, '1);
    rd(A_EVT, d);   chk("R2 cleared before rise", d, '0);
    pin_in = '1;
    wr(A_EVT, '1);
    rd(A_EVT, d);   chk("R7 set beats clear", d, '1);

    // R6 zeros leave bits alone; partial clear
    wr(A_EVT, '0);
    rd(A_EVT, d);   chk("R6 zero write", d, '1);
    wr(A_EVT, 32'h0000_FFFF);
    rd(A_EVT, d);   chk("R6 partial clear", d, 32'hFFFF_0000);

    // R5 level high with both-edges set: persists while active
    wr(A_KIND, '0); wr(A_BOTH, '1);
    @(negedge clk);
    wr(A_EVT, '1);
    rd(A_EVT, d);   chk("R5 active level re-sets", d, '1);
    pin_in = '0;
    @(negedge clk);
    wr(A_EVT, '1);
    rd(A_EVT, d);   chk("R5 inactive level clears", d, '0);
    wr(A_POL, '0);
    @(negedge clk);
    rd(A_EVT, d);   chk("R5 active-low level", d, '1);

    // R8 mask handling, mask is all ones here
    wr(A_UNMASK, 32'h0000_00F0);
    rd(A_MASK, d);  chk("R8 unmask", d, 32'hFFFF_FF0F);
    wr(A_UNMASK, '0);
    rd(A_MASK, d);  chk("R8 zero unmask", d, 32'hFFFF_FF0F);
    wr(A_MSET, 32'h0000_0010);
    rd(A_MASK, d);  chk("R8 mask set", d, 32'hFFFF_FF1F);
    wr(A_MSET, '0);
    rd(A_MASK, d);  chk("R8 zero mask set", d, 32'hFFFF_FF1F);
    wr(A_MASK, '0);
    rd(A_MASK, d);  chk("R8 view is read-only", d, 32'hFFFF_FF1F);
    wr(A_MSET, '1);
    rd(A_MASK, d);  chk("R8 mask all", d, '1);

    // R9 event caught while masked shows up on unmask
    wr(A_KIND, '1); wr(A_POL, '1); wr(A_BOTH, '0);
    repeat (2) @(negedge clk);
    wr(A_EVT, '1);
    pin_in = 32'h0000_0008;
    @(negedge clk);
    rd(A_EVT, d);   chk("R9 latched while masked", d, 32'h0000_0008);
    chk("R9 masked irq low", {31'b0, irq}, '0);
    wr(A_UNMASK, 32'h0000_0004);
    chk("R9 other pin unmasked", {31'b0, irq}, '0);
    wr(A_UNMASK, 32'h0000_0008);
    chk("R9 fires on unmask", {31'b0, irq}, 32'h1);
    wr(A_EVT, 32'h0000_0008);
    chk("R9 irq drops after clear", {31'b0, irq}, '0);

    // R10 configuration read-back and write-only reads
    wr(A_KIND, 32'h1234_5678); wr(A_POL, 32'h9ABC_DEF0); wr(A_BOTH, 32'h0F0F_0F0F);
    rd(A_KIND, d);   chk("R10 kind", d, 32'h1234_5678);
    rd(A_POL, d);    chk("R10 polarity", d, 32'h9ABC_DEF0);
    rd(A_BOTH, d);   chk("R10 both", d, 32'h0F0F_0F0F);
    rd(A_UNMASK, d); chk("R10 unmask reads 0", d, '0);
    rd(A_MSET, d);   chk("R10 mask set reads 0", d, '0);
    rd(8'h00, d);    chk("R10 unmapped reads 0", d, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule